// File: doc/BRIEF.md
# Sector write field sequencer

This block runs the data-field half of a sector write. A search stage elsewhere reports the moment it has read an ID field whose track, sector and CRC all match. From that moment this block asks the host for the first data byte and lets a fixed gap of byte times go by. It then decides whether the write can go ahead. If the host has not supplied that byte, the command is abandoned with lost data and the write gate is never raised. Otherwise the block raises the write gate and lays down the field: a short run of zero bytes, a data address mark picked by a 2-bit selector, the data bytes, the two CRC bytes and one trailing fill byte.

The serializer sends one strobe per byte time, and the block advances one byte slot on each strobe. It presents the byte for the current slot on `out_byte`, and reports on `src_sel` where that byte comes from. The host supplies data through a one-byte holding register, and a data request is raised for every byte. If the host misses a byte, zeros are written in its place, lost data is flagged, and the write carries on.

At the end of the field the write gate drops. A single-record command then pulses the interrupt and clears busy. A multi-record command instead pulses `next_sec` and goes back to searching for the next ID field.

Top module: `wfield_seq`

## Requirements
- R1: After reset, busy, wgate, drq, lost_data, irq and next_sec are all 0.
- R2: A cmd_go pulse sets busy and clears lost_data on the next cycle, and it captures mark_sel and multi. While the block is searching, an id_found pulse raises drq on the next cycle.
- R3: The block counts byte strobes after id_found. If drq is still unserviced on the 11th strobe, wgate stays 0, and on the next cycle irq pulses, busy is 0, drq is 0 and lost_data is 1.
- R4: If drq has been serviced by the 11th strobe, wgate is 1 on the next cycle. The next 6 slots present 8'h00 with src_sel 0 (zero fill).
- R5: The 7th slot after wgate rises presents the address mark with src_sel 1. The mark is 8'hFB, 8'hFA, 8'hF9 or 8'hF8 for a captured mark_sel of 0, 1, 2 or 3.
- R6: Next come 128 data slots with src_sel 2, carrying the host bytes in order. After each strobe that moves a byte out while more bytes remain, drq is 1. A host_ld clears drq on the next cycle.
- R7: If the host has not serviced a data byte by its strobe, that slot presents 8'h00, lost_data becomes 1, and the field continues.
- R8: A host_ld in the same cycle as a byte strobe counts as serviced, and its byte is used. This applies both at the 11th gap strobe and in the data field.
- R9: After the data come crc_val[15:8] and then crc_val[7:0], both with src_sel 3. Then comes 8'hFF with src_sel 4. wgate is 0 after the strobe that ends the FF slot.
- R10: At the end of the field, a single-record command pulses irq for one cycle and clears busy. A multi-record command instead pulses next_sec with irq 0 and busy kept at 1, and it accepts the next id_found.
- R11: While the block is idle, id_found and byte strobes have no effect: drq, wgate and busy stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Start a write command (pulse) |
| mark_sel | input | 2 | Address mark selector, captured at cmd_go |
| multi | input | 1 | Multi-record command flag, captured at cmd_go |
| id_found | input | 1 | Matching ID field found (pulse) |
| byte_tick | input | 1 | One pulse per byte time from the serializer |
| host_ld | input | 1 | Host wrote the data holding register |
| host_data | input | 8 | Byte written by the host |
| crc_val | input | 16 | Data CRC from the external generator |
| wgate | output | 1 | Write gate |
| src_sel | output | 3 | Byte source: 0 zero, 1 mark, 2 data, 3 CRC, 4 fill |
| out_byte | output | 8 | Byte for the current slot |
| drq | output | 1 | Data request to the host |
| lost_data | output | 1 | Sticky lost-data flag |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Completion interrupt pulse |
| next_sec | output | 1 | Multi-record restart pulse |

## Verification
The host's load of the holding register can land in the same clock as a byte strobe. This can happen at the gap decision and at any data slot, and it must be taken as a serviced request and not as a miss. Two of the table records drive host_ld during the strobe cycle, once on the 11th gap strobe and once on every data strobe. The bench then judges the written bytes, wgate and lost_data against the bytes it sent. Other records skip a byte on purpose, so that the zero substitution and the drq re-request on the following strobe are judged next to the coincident case.

// File: rtl/wfs_pkg.sv
package wfs_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_HUNT, S_GAP, S_PRE, S_MARK, S_DATA, S_CRC, S_TAIL
  } slot_e;

  typedef enum logic [2:0] {
    SRC_ZERO = 3'd0,
    SRC_MARK = 3'd1,
    SRC_DATA = 3'd2,
    SRC_CRC  = 3'd3,
    SRC_FILL = 3'd4
  } src_e;

  // Selector 0..3 maps to mark bytes FB..F8.
  function automatic logic [7:0] mark_code(input logic [1:0] sel);
    return 8'hFB - {6'd0, sel};
  endfunction

  // First CRC slot carries the high byte.
  function automatic logic [7:0] crc_pick(input logic [15:0] crc, input logic second);
    return second ? crc[7:0] : crc[15:8];
  endfunction

endpackage

// File: rtl/wfs_slot_ctl.sv
module wfs_slot_ctl
  import wfs_pkg::*;
#(
  parameter int GAP_BYTES  = 11,
  parameter int PRE_BYTES  = 6,
  parameter int DATA_BYTES = 128,
  parameter int CW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  logic [1:0]    mark_sel,
  input  logic          multi,
  input  logic          id_found,
  input  logic          byte_tick,
  input  logic          ready,
  output slot_e         st,
  output logic [CW-1:0] cnt,
  output logic [1:0]    mark_q,
  output logic          busy,
  output logic          wgate,
  output logic          irq,
  output logic          next_sec,
  output logic          ev_arm,
  output logic          ev_take,
  output logic          ev_more,
  output logic          ev_abort
);

  logic multi_q;
  logic last;

  always_comb begin
    unique case (st)
      S_GAP:   last = (cnt == CW'(GAP_BYTES - 1));
      S_PRE:   last = (cnt == CW'(PRE_BYTES - 1));
      S_DATA:  last = (cnt == CW'(DATA_BYTES - 1));
      S_CRC:   last = (cnt == CW'(1));
      default: last = 1'b1;
    endcase
  end

  assign ev_arm   = (st == S_HUNT) && id_found && !cmd_go;
  assign ev_abort = (st == S_GAP) && byte_tick && last && !ready && !cmd_go;
  assign ev_take  = byte_tick && !cmd_go &&
                    ((st == S_MARK) || ((st == S_DATA) && !last));
  assign ev_more  = (st == S_MARK) ? (DATA_BYTES > 1) : ((int'(cnt) + 2) < DATA_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      mark_q   <= '0;
      multi_q  <= 1'b0;
      busy     <= 1'b0;
      wgate    <= 1'b0;
      irq      <= 1'b0;
      next_sec <= 1'b0;
    end else begin
      irq      <= 1'b0;
      next_sec <= 1'b0;
      if (cmd_go) begin
        st      <= S_HUNT;
        cnt     <= '0;
        mark_q  <= mark_sel;
        multi_q <= multi;
        busy    <= 1'b1;
        wgate   <= 1'b0;
      end else begin
        unique case (st)
          S_HUNT: if (id_found) begin
            st  <= S_GAP;
            cnt <= '0;
          end
          S_GAP: if (byte_tick) begin
            if (!last) cnt <= cnt + 1'b1;
            else if (ready) begin
              st    <= S_PRE;
              cnt   <= '0;
              wgate <= 1'b1;
            end else begin
              st   <= S_IDLE;
              busy <= 1'b0;
              irq  <= 1'b1;
            end
          end
          S_PRE, S_DATA, S_CRC: if (byte_tick) begin
            if (!last) cnt <= cnt + 1'b1;
            else begin
              cnt <= '0;
              st  <= (st == S_PRE) ? S_MARK : (st == S_DATA) ? S_CRC : S_TAIL;
            end
          end
          S_MARK: if (byte_tick) begin
            st  <= S_DATA;
            cnt <= '0;
          end
          S_TAIL: if (byte_tick) begin
            wgate <= 1'b0;
            cnt   <= '0;
            if (multi_q) begin
              st       <= S_HUNT;
              next_sec <= 1'b1;
            end else begin
              st   <= S_IDLE;
              busy <= 1'b0;
              irq  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_abort_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!wgate && !busy && irq));

  p_wg_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wgate) |-> (st == S_PRE && cnt == '0));

  p_wg_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wgate |-> busy);

  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_restart_hunt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    next_sec |-> (st == S_HUNT && busy && !wgate && !irq));

endmodule

// File: rtl/wfs_hold_buf.sv
module wfs_hold_buf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_go,
  input  logic       arm,
  input  logic       take,
  input  logic       more,
  input  logic       abort,
  input  logic       host_ld,
  input  logic [7:0] host_data,
  output logic       ready,
  output logic       drq,
  output logic       lost,
  output logic [7:0] cur_byte
);

  logic [7:0] hold;

  assign ready = !drq || host_ld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold     <= '0;
      cur_byte <= '0;
      drq      <= 1'b0;
      lost     <= 1'b0;
    end else begin
      if (host_ld) begin
        hold <= host_data;
        drq  <= 1'b0;
      end
      if (cmd_go) begin
        drq  <= 1'b0;
        lost <= 1'b0;
      end
      if (arm) drq <= 1'b1;
      if (take) begin
        cur_byte <= host_ld ? host_data : (drq ? 8'h00 : hold);
        if (!ready) lost <= 1'b1;
        drq <= more;
      end
      if (abort) begin
        lost <= 1'b1;
        drq  <= 1'b0;
      end
    end
  end

  p_miss_lost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ready) |=> lost);

  p_ld_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ld && !take && !arm && !cmd_go) |=> !drq);

  p_take_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && more) |=> drq);

endmodule

// File: rtl/wfs_byte_mux.sv
module wfs_byte_mux
  import wfs_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_e         st,
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    mark_q,
  input  logic [7:0]    cur_byte,
  input  logic [15:0]   crc_val,
  output logic [7:0]    out_byte,
  output logic [2:0]    src_sel
);

  src_e src;

  always_comb begin
    unique case (st)
      S_MARK: begin src = SRC_MARK; out_byte = mark_code(mark_q); end
      S_DATA: begin src = SRC_DATA; out_byte = cur_byte; end
      S_CRC:  begin src = SRC_CRC;  out_byte = crc_pick(crc_val, cnt[0]); end
      S_TAIL: begin src = SRC_FILL; out_byte = 8'hFF; end
      default: begin src = SRC_ZERO; out_byte = 8'h00; end
    endcase
  end

  assign src_sel = src;

  p_mark_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'd1) |-> (out_byte[7:2] == 6'b111110));

  p_zero_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE) |-> (out_byte == 8'h00 && src_sel == 3'd0));

endmodule

// File: rtl/wfield_seq.sv
module wfield_seq
  import wfs_pkg::*;
#(
  parameter int GAP_BYTES  = 11,
  parameter int PRE_BYTES  = 6,
  parameter int DATA_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_go,
  input  logic [1:0]  mark_sel,
  input  logic        multi,
  input  logic        id_found,
  input  logic        byte_tick,
  input  logic        host_ld,
  input  logic [7:0]  host_data,
  input  logic [15:0] crc_val,
  output logic        wgate,
  output logic [2:0]  src_sel,
  output logic [7:0]  out_byte,
  output logic        drq,
  output logic        lost_data,
  output logic        busy,
  output logic        irq,
  output logic        next_sec
);

  localparam int MAXC = (DATA_BYTES > GAP_BYTES) ?
                        ((DATA_BYTES > PRE_BYTES) ? DATA_BYTES : PRE_BYTES) :
                        ((GAP_BYTES > PRE_BYTES) ? GAP_BYTES : PRE_BYTES);
  localparam int CW = $clog2(MAXC + 1);

  slot_e         st;
  logic [CW-1:0] cnt;
  logic [1:0]    mark_q;
  logic          ev_arm, ev_take, ev_more, ev_abort, ready;
  logic [7:0]    cur_byte;

  wfs_slot_ctl #(
    .GAP_BYTES(GAP_BYTES), .PRE_BYTES(PRE_BYTES),
    .DATA_BYTES(DATA_BYTES), .CW(CW)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .mark_sel(mark_sel),
    .multi(multi), .id_found(id_found), .byte_tick(byte_tick), .ready(ready),
    .st(st), .cnt(cnt), .mark_q(mark_q), .busy(busy), .wgate(wgate),
    .irq(irq), .next_sec(next_sec), .ev_arm(ev_arm), .ev_take(ev_take),
    .ev_more(ev_more), .ev_abort(ev_abort)
  );

  wfs_hold_buf u_buf (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .arm(ev_arm), .take(ev_take),
    .more(ev_more), .abort(ev_abort), .host_ld(host_ld), .host_data(host_data),
    .ready(ready), .drq(drq), .lost(lost_data), .cur_byte(cur_byte)
  );

  wfs_byte_mux #(.CW(CW)) u_mux (
    .clk(clk), .rst_n(rst_n), .st(st), .cnt(cnt), .mark_q(mark_q),
    .cur_byte(cur_byte), .crc_val(crc_val), .out_byte(out_byte), .src_sel(src_sel)
  );

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_go) |=> (!drq && !wgate));

endmodule

// File: tb/wfield_seq_test.sv
module wfield_seq_test;

  localparam int DB = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_go = 1'b0, multi = 1'b0, id_found = 1'b0;
  logic        byte_tick = 1'b0, host_ld = 1'b0;
  logic [1:0]  mark_sel = 2'd0;
  logic [7:0]  host_data = 8'h00;
  logic [15:0] crc_val = 16'h0000;
  logic        wgate, drq, lost_data, busy, irq, next_sec;
  logic [2:0]  src_sel;
  logic [7:0]  out_byte;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wfield_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .mark_sel(mark_sel),
    .multi(multi), .id_found(id_found), .byte_tick(byte_tick),
    .host_ld(host_ld), .host_data(host_data), .crc_val(crc_val),
    .wgate(wgate), .src_sel(src_sel), .out_byte(out_byte), .drq(drq),
    .lost_data(lost_data), .busy(busy), .irq(irq), .next_sec(next_sec)
  );

  // {coincident load, mark select, missed byte index (FF none), crc}
  localparam logic [26:0] VEC [4] = '{
    {1'b0, 2'd0, 8'hFF, 16'h1234},
    {1'b1, 2'd1, 8'hFF, 16'hABCD},
    {1'b0, 2'd2, 8'h05, 16'h0F0F},
    {1'b1, 2'd3, 8'h7F, 16'h8001}
  };

  function automatic logic [7:0] dpat(input int k, input int r);
    return 8'((k * 37) + (r * 11) + 5);
  endfunction

  function automatic logic [7:0] exp_mark(input logic [1:0] s);
    case (s)
      2'd0: return 8'hFB;
      2'd1: return 8'hFA;
      2'd2: return 8'hF9;
      default: return 8'hF8;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_go(input logic [1:0] mk, input logic mul);
    @(negedge clk); cmd_go = 1'b1; mark_sel = mk; multi = mul;
    @(negedge clk); cmd_go = 1'b0;
  endtask

  task automatic pulse_id();
    @(negedge clk); id_found = 1'b1;
    @(negedge clk); id_found = 1'b0;
  endtask

  task automatic hload(input logic [7:0] d);
    @(negedge clk); host_ld = 1'b1; host_data = d;
    @(negedge clk); host_ld = 1'b0;
  endtask

  task automatic strobe(input bit ld, input logic [7:0] d);
    @(negedge clk); byte_tick = 1'b1; host_ld = ld; host_data = d;
    @(negedge clk); byte_tick = 1'b0; host_ld = 1'b0;
  endtask

  task automatic do_record(input int r, input logic [1:0] mk, input bit co,
                           input int miss, input logic [15:0] crc,
                           input bit go, input bit mul);
    bit ld;
    logic [7:0] e;
    crc_val = crc;
    if (go) begin
      pulse_go(mk, mul);
      check(busy == 1'b1, "R2 busy after go", busy, 1);
      check(lost_data == 1'b0, "R2 lost cleared", lost_data, 0);
    end
    pulse_id();
    check(drq == 1'b1, "R2 drq after id", drq, 1);
    if (!co) begin
      hload(dpat(0, r));
      check(drq == 1'b0, "R6 drq cleared by load", drq, 0);
    end
    repeat (10) strobe(1'b0, 8'h00);
    check(wgate == 1'b0, "R3 wgate low in gap", wgate, 0);
    strobe(co, dpat(0, r));
    check(wgate == 1'b1, co ? "R8 gap coincident load" : "R4 wgate rises", wgate, 1);
    for (int s = 0; s < 6; s++) begin
      check(out_byte == 8'h00 && src_sel == 3'd0, "R4 zero preamble",
            {src_sel, out_byte}, 0);
      strobe(1'b0, 8'h00);
    end
    check(out_byte == exp_mark(mk) && src_sel == 3'd1, "R5 address mark",
          {src_sel, out_byte}, {3'd1, exp_mark(mk)});
    strobe(1'b0, 8'h00);
    check(drq == 1'b1, "R6 drq after mark", drq, 1);
    for (int k = 0; k < DB; k++) begin
      e = (k == miss) ? 8'h00 : dpat(k, r);
      check(out_byte == e && src_sel == 3'd2, (k == miss) ? "R7 zero for missed byte" :
            (co ? "R8 coincident data" : "R6 data byte"), {src_sel, out_byte}, {3'd2, e});
      ld = drq && ((k + 1) != miss) && (k + 1 < DB);
      if (co) strobe(ld, dpat(k + 1, r));
      else begin
        if (ld) hload(dpat(k + 1, r));
        strobe(1'b0, 8'h00);
      end
      if (k < DB - 1)
        check(drq == (k + 1 < DB - 1), "R6 drq per byte", drq, (k + 1 < DB - 1));
    end
    check(lost_data == (miss >= 0), "R7 lost flag", lost_data, (miss >= 0));
    check(out_byte == crc[15:8] && src_sel == 3'd3, "R9 crc high",
          {src_sel, out_byte}, {3'd3, crc[15:8]});
    strobe(1'b0, 8'h00);
    check(out_byte == crc[7:0] && src_sel == 3'd3, "R9 crc low",
          {src_sel, out_byte}, {3'd3, crc[7:0]});
    strobe(1'b0, 8'h00);
    check(out_byte == 8'hFF && src_sel == 3'd4 && wgate, "R9 fill byte",
          {wgate, src_sel, out_byte}, {1'b1, 3'd4, 8'hFF});
    strobe(1'b0, 8'h00);
    check(wgate == 1'b0, "R9 wgate drops", wgate, 0);
    if (mul) begin
      check(next_sec && !irq && busy, "R10 multi restart",
            {next_sec, irq, busy}, 3'b101);
    end else begin
      check(irq && !busy && !next_sec, "R10 single end",
            {next_sec, irq, busy}, 3'b010);
    end
    @(negedge clk);
    check(irq == 1'b0 && next_sec == 1'b0, "R10 one-cycle pulse", {irq, next_sec}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, wgate, drq, lost_data, irq, next_sec} == 6'b0, "R1 reset state",
          {busy, wgate, drq, lost_data, irq, next_sec}, 0);

    // R11: idle ignores id_found and strobes
    pulse_id();
    repeat (3) strobe(1'b0, 8'h00);
    check(!drq && !wgate && !busy, "R11 idle ignores inputs", {drq, wgate, busy}, 0);

    // Table walk
    for (int i = 0; i < 4; i++) begin
      do_record(i, VEC[i][25:24], VEC[i][26],
                (VEC[i][23:16] == 8'hFF) ? -1 : int'(VEC[i][23:16]),
                VEC[i][15:0], 1'b1, 1'b0);
    end

    // R3: gap abort without service
    pulse_go(2'd0, 1'b0);
    pulse_id();
    repeat (10) strobe(1'b0, 8'h00);
    check(busy && !wgate, "R3 still waiting", {busy, wgate}, 2'b10);
    strobe(1'b0, 8'h00);
    check(!wgate && irq && !busy && !drq && lost_data, "R3 abort",
          {wgate, irq, busy, drq, lost_data}, 5'b01001);
    repeat (2) strobe(1'b0, 8'h00);
    check(!wgate && !busy, "R11 no write after abort", {wgate, busy}, 0);

    // R10: multi-record, two sectors
    do_record(4, 2'd1, 1'b0, -1, 16'h5A5A, 1'b1, 1'b1);
    do_record(5, 2'd1, 1'b1, 9, 16'hC3C3, 1'b0, 1'b1);
    check(busy == 1'b1, "R10 still searching", busy, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule